// File: doc/BRIEF.md
# Serial Gamma Register Command Decoder

This block decodes command transactions that arrive from a byte-level serial front end. The front end reports three kinds of bus event: a start condition, a stop condition, and a byte. A byte carries a direction flag, which is 0 for a byte received from the controller and 1 for a byte the controller reads. The decoder owns a file of seventeen 10-bit registers: fourteen gamma channels, two common-voltage levels and one write-disable flag. For each byte it returns an acknowledge and, on reads, a data byte. Every register update appears on a write strobe. A small internal non-volatile store holds default values, and commands can copy these defaults into one register or into all registers.

After a start condition, the first byte carries the device address and the read/write bit. In a write transaction, the next byte is a command byte. Its top three bits select the operation: register access, copy of one channel, or copy of all channels. Its low five bits give the register address. A register access then takes pairs of data bytes and moves through the valid addresses one pair at a time. A read transaction returns register contents two bytes per register, starting at the last address selected.

The decoder is written as a single state machine with these states: `S_IDLE`, `S_DEV` (expects the device byte), `S_CMD` (expects the command byte), `S_WHI` / `S_WLO` (expect the high / low data byte), `S_RD` (returns read bytes), `S_ACQ_ONE` / `S_ACQ_ALL` (a copy command is waiting for stop), `S_COPY` (runs the copy-all sweep) and `S_SKIP` (refuses everything until the next start). The transitions are:
- start: any state except `S_COPY` goes to `S_DEV`.
- stop: `S_ACQ_ONE` writes its register and goes to `S_IDLE`. `S_ACQ_ALL` goes to `S_COPY`. Every other state except `S_COPY` goes to `S_IDLE`.
- `S_DEV`: an address match goes to `S_CMD` or `S_RD`. A mismatch goes to `S_SKIP`.
- `S_CMD`: a valid command goes to `S_WHI`, `S_ACQ_ALL` or `S_ACQ_ONE`. Anything else goes to `S_SKIP`.
- `S_WHI` goes to `S_WLO`, and `S_WLO` goes back to `S_WHI`.
- `S_COPY` goes to `S_IDLE` after its last entry.
- A byte that a state does not accept goes to `S_SKIP`.

Top module: `gamma_cmd_decoder`

## Requirements
- R1: In `S_DEV`, a byte whose bits 7:1 equal the device address DEV_ADDR (default 7'h4C) is acknowledged. Its bit 0 selects a write transaction (0) or a read transaction (1). On a mismatch the byte is not acknowledged, and every byte is refused until the next start.
- R2: A command byte with bits 7:5 = 000 and a valid address in bits 4:0 is acknowledged, and it sets the register pointer to that address.
- R3: The only valid addresses are 0 to 13 (channels), 18 and 19 (common levels) and 20 (write-disable). A command byte with any other address, or with a bits 7:5 value other than 000, 010 or 100, is not acknowledged. Every write strobe names a valid address.
- R4: Data arrives as a high byte followed by a low byte. The value is {high[1:0], low[7:0]}. Both bytes are acknowledged. The write strobe (reg_we, reg_addr, reg_wdata) appears in the same cycle as the response to the low byte, and the register holds the value from the following cycle.
- R5: If bits 7:6 of the high byte are 01, the pair is acknowledged but nothing is written.
- R6: A stop or a start that arrives between the high byte and the low byte cancels the pair. No strobe is issued and the register is unchanged.
- R7: After each pair, the pointer moves to the next valid address (13 is followed by 18). After the pair written to address 20, the data bytes that follow are not acknowledged.
- R8: Bit 0 of the low byte written to address 20 sets the write-disable flag (wd_flag). While the flag is 1, pairs sent to addresses 0 to 19 are acknowledged but not written. Address 20 can still be written.
- R9: In a read transaction, each byte with direction 1 is acknowledged and returns {6'b0, value[9:8]} and then value[7:0] for the register at the pointer. The pointer then advances as in R7. Once the pointer has passed address 20, reads return 8'h00.
- R10: A command byte with bits 7:5 = 100 and a valid address, followed by stop, starts a copy of all entries. In the cycles after the stop, seventeen consecutive strobes write addresses 0 to 13, 18, 19 and 20 in that order. The value for channel index i (0 to 15) is (37*i + 5) mod 1024, and the value for address 20 is 0. Bus events during the sweep are ignored, and bytes during the sweep are refused.
- R11: A command byte with bits 7:5 = 010 and a valid address, followed by stop, writes the stored default into that one register. The strobe appears in the cycle after the stop. The copy happens even while the write-disable flag is 1.
- R12: Each byte event is answered with rsp_vld for exactly one cycle, one cycle after the event. No response appears without a byte event.
- R13: After reset all registers are 0, wd_flag is 0, the pointer is at address 0, and no strobe or response is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start or repeated-start event |
| ev_stop | input | 1 | Stop event |
| ev_byte | input | 1 | Byte event |
| ev_dir | input | 1 | Byte direction: 0 = received from the controller, 1 = read by the controller |
| ev_data | input | 8 | Received byte |
| rsp_vld | output | 1 | Response to a byte event is valid |
| rsp_ack | output | 1 | Acknowledge for the byte |
| rsp_data | output | 8 | Byte returned on a read |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 5 | Bus address of the register written |
| reg_wdata | output | 10 | Value written |
| wd_flag | output | 1 | Current write-disable flag |

## Verification
The hardest situation to bring about is the copy-all sweep, together with the write-disable flag. The sweep must be checked on seventeen consecutive cycles, beginning at the exact cycle after the stop. The disabled writes must be shown to leave their registers unchanged. To reach both, the stimulus first sets the flag through address 20 and sends a write that the flag suppresses. It then sends a single-channel copy, and finally a copy-all, which also clears the flag. Register contents are read back through read transactions.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
    localparam int NREG  = 17;
    localparam int AW    = 5;
    localparam int DW    = 10;
    localparam int CH_HI = 13;
    localparam int GAP   = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_CMD, S_WHI, S_WLO, S_RD,
        S_ACQ_ONE, S_ACQ_ALL, S_COPY, S_SKIP
    } st_t;

    function automatic logic addr_ok(input logic [AW-1:0] a);
        return (a <= AW'(CH_HI)) || (a == AW'(CH_HI + GAP + 1)) ||
               (a == AW'(CH_HI + GAP + 2)) || (a == AW'(CH_HI + GAP + 3));
    endfunction

    function automatic logic [AW-1:0] a2i(input logic [AW-1:0] a);
        return (a <= AW'(CH_HI)) ? a : a - AW'(GAP);
    endfunction

    function automatic logic [AW-1:0] i2a(input logic [AW-1:0] i);
        return (i <= AW'(CH_HI)) ? i : i + AW'(GAP);
    endfunction
endpackage

// File: rtl/gcd_nvstore.sv
module gcd_nvstore
    import gcd_pkg::*;
#(
    parameter int NV_SEED = 5,
    parameter int NV_STEP = 37,
    parameter int NV_WD   = 0
) (
    input  logic [AW-1:0] idx,
    output logic [DW-1:0] val
);
    logic [31:0] prod;

    always_comb begin
        prod = 32'(idx) * 32'(NV_STEP) + 32'(NV_SEED);
        if (idx == AW'(NREG - 1)) val = DW'(NV_WD);
        else                      val = prod[DW-1:0];
    end
endmodule

// File: rtl/gcd_regfile.sv
module gcd_regfile
    import gcd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic          wd_flag
);
    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    logic [DW-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g == NREG - 1) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        mem[g] <= '0;
                else if (we && widx == AW'(g))     mem[g] <= {{(DW-1){1'b0}}, wdata[0]};
            end
        end else begin : g_val
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                        mem[g] <= '0;
                else if (we && widx == AW'(g))     mem[g] <= wdata;
            end
        end
    end

    assign rdata   = (ridx <= LAST) ? mem[ridx] : '0;
    assign wd_flag = mem[NREG-1][0];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx < LAST) |=> (ridx != $past(widx)) || (rdata == $past(wdata))); // R4
endmodule

// File: rtl/gcd_fsm.sv
module gcd_fsm
    import gcd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_byte,
    input  logic          ev_dir,
    input  logic [7:0]    ev_data,
    input  logic          wd_flag,
    input  logic [DW-1:0] nv_val,
    input  logic [DW-1:0] rd_val,
    output logic [AW-1:0] nv_idx,
    output logic [AW-1:0] rd_idx,
    output logic          rsp_vld,
    output logic          rsp_ack,
    output logic [7:0]    rsp_data,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata
);
    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    st_t           state, n_state;
    logic [AW-1:0] ptr, n_ptr, cnt, n_cnt;
    logic          pend, n_pend, rph, n_rph, bus_wr, n_bus;
    logic [7:0]    hi, n_hi, n_rd;
    logic          n_rv, n_ack, n_we;
    logic [AW-1:0] n_addr;
    logic [DW-1:0] n_wdata;

    assign nv_idx = (state == S_COPY) ? cnt : ptr;
    assign rd_idx = ptr;

    always_comb begin
        n_state = state;  n_ptr = ptr;   n_pend = pend;  n_cnt = cnt;
        n_hi    = hi;     n_rph = rph;   n_rv = 1'b0;    n_ack = 1'b0;
        n_rd    = 8'h00;  n_we  = 1'b0;  n_bus = 1'b0;
        n_addr  = reg_addr; n_wdata = reg_wdata;
        if (state == S_COPY) begin
            n_we    = 1'b1;
            n_addr  = i2a(cnt);
            n_wdata = nv_val;
            n_cnt   = cnt + 1'b1;
            n_rv    = ev_byte;
            if (cnt == LAST) n_state = S_IDLE;
        end else if (ev_start) begin
            n_state = S_DEV;
        end else if (ev_stop) begin
            n_state = S_IDLE;
            if (state == S_ACQ_ALL) begin
                n_state = S_COPY;
                n_cnt   = '0;
            end else if (state == S_ACQ_ONE) begin
                n_we    = 1'b1;
                n_addr  = i2a(ptr);
                n_wdata = nv_val;
            end
        end else if (ev_byte) begin
            n_rv    = 1'b1;
            n_state = S_SKIP;
            unique case (state)
                S_DEV: begin
                    if (!ev_dir && ev_data[7:1] == DEV_ADDR) begin
                        n_ack   = 1'b1;
                        n_rph   = 1'b0;
                        n_state = ev_data[0] ? S_RD : S_CMD;
                    end
                end
                S_CMD: begin
                    if (!ev_dir && addr_ok(ev_data[4:0])) begin
                        if (ev_data[7:5] == 3'b000) begin
                            n_ack = 1'b1; n_ptr = a2i(ev_data[4:0]);
                            n_pend = 1'b0; n_state = S_WHI;
                        end else if (ev_data[7:5] == 3'b100) begin
                            n_ack = 1'b1; n_state = S_ACQ_ALL;
                        end else if (ev_data[7:5] == 3'b010) begin
                            n_ack = 1'b1; n_ptr = a2i(ev_data[4:0]);
                            n_pend = 1'b0; n_state = S_ACQ_ONE;
                        end
                    end
                end
                S_WHI: begin
                    if (!ev_dir && !pend) begin
                        n_ack = 1'b1; n_hi = ev_data; n_state = S_WLO;
                    end
                end
                S_WLO: begin
                    if (!ev_dir) begin
                        n_ack   = 1'b1;
                        n_state = S_WHI;
                        if (hi[7:6] != 2'b01 && (!wd_flag || ptr == LAST)) begin
                            n_we    = 1'b1;
                            n_bus   = 1'b1;
                            n_addr  = i2a(ptr);
                            n_wdata = {hi[1:0], ev_data};
                        end
                        if (ptr == LAST) n_pend = 1'b1;
                        else             n_ptr  = ptr + 1'b1;
                    end
                end
                S_RD: begin
                    if (ev_dir) begin
                        n_ack   = 1'b1;
                        n_state = S_RD;
                        n_rph   = !rph;
                        if (!pend) begin
                            n_rd = rph ? rd_val[7:0] : {6'b0, rd_val[DW-1:8]};
                            if (rph) begin
                                if (ptr == LAST) n_pend = 1'b1;
                                else             n_ptr  = ptr + 1'b1;
                            end
                        end
                    end
                end
                default: n_state = S_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; ptr <= '0; cnt <= '0; pend <= 1'b0; rph <= 1'b0;
            hi <= '0; rsp_vld <= 1'b0; rsp_ack <= 1'b0; rsp_data <= '0;
            reg_we <= 1'b0; reg_addr <= '0; reg_wdata <= '0; bus_wr <= 1'b0;
        end else begin
            state <= n_state; ptr <= n_ptr; cnt <= n_cnt; pend <= n_pend;
            rph <= n_rph; hi <= n_hi; rsp_vld <= n_rv; rsp_ack <= n_ack;
            rsp_data <= n_rd; reg_we <= n_we; reg_addr <= n_addr;
            reg_wdata <= n_wdata; bus_wr <= n_bus;
        end
    end

    AST_RSP_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $past(ev_byte)); // R12
    AST_BUS_WE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && bus_wr) |-> $past(ev_byte && !ev_dir)); // R4
    AST_WD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && bus_wr && reg_addr != i2a(LAST)) |-> !$past(wd_flag)); // R8
    AST_WE_ADDR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> addr_ok(reg_addr)); // R3
    AST_COPY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COPY) |-> (cnt <= LAST)); // R10
endmodule

// File: rtl/gamma_cmd_decoder.sv
module gamma_cmd_decoder
    import gcd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter int         NV_SEED  = 5,
    parameter int         NV_STEP  = 37,
    parameter int         NV_WD    = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       ev_byte,
    input  logic       ev_dir,
    input  logic [7:0] ev_data,
    output logic       rsp_vld,
    output logic       rsp_ack,
    output logic [7:0] rsp_data,
    output logic       reg_we,
    output logic [4:0] reg_addr,
    output logic [9:0] reg_wdata,
    output logic       wd_flag
);
    logic [AW-1:0] nv_idx, rd_idx;
    logic [DW-1:0] nv_val, rd_val;

    gcd_nvstore #(.NV_SEED(NV_SEED), .NV_STEP(NV_STEP), .NV_WD(NV_WD)) u_nv (
        .idx(nv_idx), .val(nv_val)
    );

    gcd_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .widx(a2i(reg_addr)),
        .wdata(reg_wdata), .ridx(rd_idx), .rdata(rd_val), .wd_flag(wd_flag)
    );

    gcd_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .ev_dir(ev_dir), .ev_data(ev_data),
        .wd_flag(wd_flag), .nv_val(nv_val), .rd_val(rd_val),
        .nv_idx(nv_idx), .rd_idx(rd_idx), .rsp_vld(rsp_vld),
        .rsp_ack(rsp_ack), .rsp_data(rsp_data), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );
endmodule

// File: tb/gamma_cmd_decoder_bench.sv
module gamma_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] DEV_W = 8'h98;
    localparam logic [7:0] DEV_R = 8'h99;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_dir = 0;
    logic [7:0] ev_data = '0;
    logic rsp_vld, rsp_ack, reg_we, wd_flag;
    logic [7:0] rsp_data;
    logic [4:0] reg_addr;
    logic [9:0] reg_wdata;

    int n_run = 0, n_fail = 0, cyc = 0;
    logic c_vld, c_ack, c_we;
    logic [7:0] c_data;
    logic [4:0] c_addr;
    logic [9:0] c_wdata;
    logic [9:0] exp_r [17];

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_cmd_decoder u_gamma_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .ev_dir(ev_dir), .ev_data(ev_data),
        .rsp_vld(rsp_vld), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .wd_flag(wd_flag)
    );

    function automatic logic [9:0] nv(input int i);
        return (i == 16) ? 10'd0 : 10'((37 * i + 5) % 1024);
    endfunction
    function automatic int a2i(input int a);
        return (a <= 13) ? a : a - 4;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic capture();
        c_vld = rsp_vld; c_ack = rsp_ack; c_data = rsp_data;
        c_we = reg_we; c_addr = reg_addr; c_wdata = reg_wdata;
    endtask

    task automatic do_start();
        @(negedge clk); ev_start = 1;
        @(negedge clk); ev_start = 0; capture();
    endtask
    task automatic do_stop();
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0; capture();
    endtask
    task automatic send(input logic [7:0] b, input logic dir);
        @(negedge clk); ev_byte = 1; ev_data = b; ev_dir = dir;
        @(negedge clk); ev_byte = 0; ev_dir = 0; capture();
    endtask

    task automatic read_pair(input int addr, output logic [9:0] v);
        logic [7:0] h;
        do_start(); send(DEV_W, 0); send(8'(addr), 0);
        do_start(); send(DEV_R, 0);
        send(8'h00, 1); h = c_data;
        send(8'h00, 1);
        v = {h[1:0], c_data};
        do_stop();
    endtask

    task automatic write_one(input int addr, input logic [9:0] v);
        do_start(); send(DEV_W, 0); send(8'(addr), 0);
        send({6'b0, v[9:8]}, 0); send(v[7:0], 0); do_stop();
    endtask

    task automatic t_reset();
        logic [9:0] v;
        chk(!rsp_vld && !reg_we && !wd_flag, "R13 idle outputs", int'({rsp_vld, reg_we, wd_flag}), 0);
        do_start(); send(DEV_R, 0);
        send(8'h00, 1); chk(c_vld && c_ack && c_data == 8'h00, "R13 read at ptr 0 hi", c_data, 0);
        send(8'h00, 1); chk(c_data == 8'h00, "R13 read at ptr 0 lo", c_data, 0);
        do_stop();
        read_pair(18, v); chk(v == 0, "R13 reg 18 reset", v, 0);
    endtask

    task automatic t_write();
        logic [9:0] v;
        do_start();
        send(DEV_W, 0); chk(c_vld && c_ack, "R1 device write ack", c_ack, 1);
        send(8'h03, 0); chk(c_ack, "R2 cmd ack", c_ack, 1);
        send(8'h02, 0); chk(c_ack && !c_we, "R4 hi ack no strobe", int'({c_ack, c_we}), 2);
        send(8'hA5, 0);
        chk(c_ack && c_we && c_addr == 5'd3 && c_wdata == 10'h2A5, "R4 strobe", c_wdata, 10'h2A5);
        do_stop();
        exp_r[3] = 10'h2A5;
        read_pair(3, v); chk(v == 10'h2A5, "R9 readback ch3", v, 10'h2A5);
    endtask

    task automatic t_invalid();
        foreach (exp_r[i]) begin end
        do_start(); send(DEV_W, 0); send(8'h0E, 0); chk(!c_ack, "R3 addr 14 nack", c_ack, 0);
        send(8'h01, 0); chk(!c_ack, "R3 follow-on nack", c_ack, 0);
        do_start(); send(DEV_W, 0); send(8'h15, 0); chk(!c_ack, "R3 addr 21 nack", c_ack, 0);
        do_start(); send(DEV_W, 0); send(8'h23, 0); chk(!c_ack, "R3 prefix 001 nack", c_ack, 0);
        do_start(); send(DEV_W, 0); send(8'h8F, 0); chk(!c_ack, "R3 copy bad addr nack", c_ack, 0);
        do_start(); send(8'hA4, 0); chk(c_vld && !c_ack, "R1 device mismatch nack", c_ack, 0);
        send(8'h03, 0); chk(!c_ack, "R1 ignored until start", c_ack, 0);
        do_stop();
    endtask

    task automatic t_autoinc();
        logic [9:0] v;
        int addrs [5] = '{12, 13, 18, 19, 20};
        logic [9:0] vals [5] = '{10'h101, 10'h202, 10'h303, 10'h004, 10'h000};
        do_start(); send(DEV_W, 0); send(8'd12, 0);
        for (int k = 0; k < 5; k++) begin
            send({6'b0, vals[k][9:8]}, 0);
            send(vals[k][7:0], 0);
            chk(c_ack && c_we && c_addr == 5'(addrs[k]) && c_wdata == vals[k], "R7 auto-increment strobe", c_addr, addrs[k]);
            exp_r[a2i(addrs[k])] = (addrs[k] == 20) ? 10'd0 : vals[k];
        end
        send(8'h00, 0); chk(!c_ack, "R7 nack after addr 20", c_ack, 0);
        do_stop();
        do_start(); send(DEV_W, 0); send(8'd13, 0); do_start(); send(DEV_R, 0);
        send(8'h00, 1); send(8'h00, 1);
        send(8'h00, 1); chk(c_ack && c_data == {6'b0, exp_r[14][9:8]}, "R9 read crosses 13 to 18 hi", c_data, exp_r[14][9:8]);
        send(8'h00, 1); chk(c_data == exp_r[14][7:0], "R9 read crosses 13 to 18 lo", c_data, exp_r[14][7:0]);
        do_stop();
        do_start(); send(DEV_W, 0); send(8'd20, 0); do_start(); send(DEV_R, 0);
        send(8'h00, 1); send(8'h00, 1);
        send(8'h00, 1); chk(c_ack && c_data == 8'h00, "R9 read past end", c_data, 0);
        do_stop();
        read_pair(19, v); chk(v == 10'h004, "R7 reg 19 value", v, 4);
    endtask

    task automatic t_marker_cancel();
        logic [9:0] v;
        do_start(); send(DEV_W, 0); send(8'd5, 0);
        send(8'h41, 0); send(8'h77, 0);
        chk(c_ack && !c_we, "R5 marker pair acked not written", int'({c_ack, c_we}), 2);
        do_stop();
        read_pair(5, v); chk(v == exp_r[5], "R5 reg unchanged", v, exp_r[5]);
        do_start(); send(DEV_W, 0); send(8'd7, 0); send(8'h03, 0);
        do_stop(); chk(!c_we, "R6 stop cancels", c_we, 0);
        do_start(); send(DEV_W, 0); send(8'd7, 0); send(8'h03, 0);
        do_start(); chk(!c_we, "R6 start cancels", c_we, 0);
        do_stop();
        read_pair(7, v); chk(v == exp_r[7], "R6 reg 7 unchanged", v, exp_r[7]);
    endtask

    task automatic t_wd_copy_one();
        logic [9:0] v;
        write_one(20, 10'h001);
        chk(wd_flag == 1'b1, "R8 flag set", wd_flag, 1);
        do_start(); send(DEV_W, 0); send(8'd5, 0); send(8'h01, 0); send(8'h11, 0);
        chk(c_ack && !c_we, "R8 disabled write acked no strobe", int'({c_ack, c_we}), 2);
        do_stop();
        read_pair(5, v); chk(v == exp_r[5], "R8 reg unchanged", v, exp_r[5]);
        do_start(); send(DEV_W, 0); send(8'h45, 0); chk(c_ack, "R11 copy-one ack", c_ack, 1);
        do_stop();
        chk(c_we && c_addr == 5'd5 && c_wdata == nv(5), "R11 copy-one strobe under flag", c_wdata, nv(5));
        exp_r[5] = nv(5);
        do_start(); send(DEV_W, 0); send(8'h53, 0); do_stop();
        chk(c_we && c_addr == 5'd19 && c_wdata == nv(15), "R11 copy-one addr 19", c_wdata, nv(15));
        exp_r[15] = nv(15);
        read_pair(5, v); chk(v == nv(5), "R11 readback ch5", v, nv(5));
    endtask

    task automatic t_copy_all();
        logic [9:0] v;
        do_start(); send(DEV_W, 0); send(8'h80, 0); chk(c_ack, "R10 copy-all ack", c_ack, 1);
        do_stop();
        for (int i = 0; i < 17; i++) begin
            @(negedge clk);
            chk(reg_we && reg_addr == 5'((i <= 13) ? i : i + 4) && reg_wdata == nv(i),
                "R10 sweep strobe", int'(reg_addr), (i <= 13) ? i : i + 4);
            exp_r[i] = nv(i);
        end
        @(negedge clk); chk(!reg_we && !wd_flag, "R10 sweep ends, flag cleared", int'({reg_we, wd_flag}), 0);
        read_pair(18, v); chk(v == nv(14), "R10 readback 18", v, nv(14));
        read_pair(3, v); chk(v == nv(3), "R10 readback ch3", v, nv(3));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        foreach (exp_r[i]) exp_r[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_invalid();
        t_autoinc();
        t_marker_cancel();
        t_wd_copy_one();
        t_copy_all();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule